// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides whether a received CAN frame should be kept. It compares the frame identifier against up to six configurable filter banks. It reports whether any active filter accepts the frame and, when one does, the number of the accepting filter. Each bank holds eight configuration bytes. Per bank, software chooses one of two layouts. In the 32-bit layout the bank forms one wide filter or two. In the 16-bit layout it forms two independent halves. Each half is either a mask pair or a list of exact identifiers.

Frames arrive on a valid/ready stream: an identifier, the IDE bit and the RTR bit. The block never applies back-pressure, so `frm_ready` is always high and every cycle with `frm_valid` high is one frame. One clock later a single-cycle `res_done` pulse carries the verdict. The verdict is held on `res_accept` and `res_fnum` until the next frame. Configuration is loaded through a byte-wide write port. A write takes effect on the clock edge that performs it, so the frame sampled on that same edge still sees the old setting.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `res_done`, `res_accept` and `res_fnum` are 0. Every filter byte and bank control field is 0, so no bank is active and no frame is accepted.
- R2: `frm_ready` is always 1. Each cycle with `frm_valid` high produces a `res_done` pulse exactly one clock later, lasting one cycle. `res_done` never rises without a frame.
- R3: The write port has this address map. Address 8*b+k (k = 0..7) loads byte k+1 of bank b. Address 8*NUM_BANKS+b loads the control of bank b, with these fields: bits [1:0] scale (2'b11 selects 32-bit, any other value selects 16-bit), bit 2 low-half mode, bit 3 high-half mode (0 = mask, 1 = list), bit 4 active. Other addresses are ignored. A 32-bit filter word is the concatenation of bytes 1..4 (or 5..8), most significant first. The fields of that word, from the top bit down, are: id[10:0] for a standard frame or id[28:18] for an extended one, RTR, IDE, id[17:0] (extended only), and a final 0. A 16-bit filter halfword is the top 16 bits of that word, built from two consecutive bytes.
- R4: In 32-bit mask mode (low-half mode bit 0), bytes 1..4 are the identifier and bytes 5..8 are the mask, giving one filter. A mask bit of 1 demands equality and a mask bit of 0 is ignored.
- R5: In 32-bit list mode, bytes 1..4 and bytes 5..8 are two exact identifiers. They carry consecutive filter numbers, the lower number going to bytes 1..4.
- R6: In 16-bit scale the low half (bytes 1..4) and the high half (bytes 5..8) are set independently. In mask mode a half is one filter: the identifier is in its first halfword and the mask in its second. In list mode a half is two exact filters. Numbering runs low half before high half, and halfwords in byte order.
- R7: For a frame with IDE = 0, the extended identifier positions (id[17:0] field and trailing bit in a word, bottom three bits of a halfword) are left out of every comparison.
- R8: An inactive bank never accepts and takes no filter numbers. Numbers count from 0 over active banks in ascending bank order.
- R9: When several filters accept a frame, the lowest number is reported. When none accepts, `res_accept` is 0 and `res_fnum` is 0.
- R10: A configuration write on the same edge that samples a frame does not affect that frame's result, only the results of later frames.
- R11: Between `res_done` pulses, `res_accept` and `res_fnum` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| frm_valid | input | 1 | Frame identifier valid |
| frm_ready | output | 1 | Always high; the block takes a frame every cycle |
| frm_ide | input | 1 | Frame uses extended identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Identifier; a standard frame uses bits [10:0] |
| res_done | output | 1 | One-cycle pulse, one clock after a frame |
| res_accept | output | 1 | Some active filter accepted the last frame |
| res_fnum | output | 5 | Number of the accepting filter |

## Verification
All state that matters here lives in the configuration bytes and bank controls. Any corruption of that state surfaces on the very next `res_done` pulse, one clock after a frame that touches the damaged filter. A wrong per-bank filter count is more visible than a wrong comparison. It does not stay local: it shifts the reported number of every filter in later banks, so a frame matching a high bank reveals it. A flaw in the standard-frame care mask shows only when a filter holds nonzero bits in the extended positions, so such filters are deliberately loaded.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

  typedef struct packed {
    logic       active;
    logic       mode_hi;
    logic       mode_lo;
    logic [1:0] scale;
  } bank_ctrl_t;

  localparam logic [1:0] SCALE_WIDE = 2'b11;

  function automatic logic agree32(input logic [31:0] k, input logic [31:0] f,
                                   input logic [31:0] m);
    return ((k ^ f) & m) == 32'd0;
  endfunction

  function automatic logic agree16(input logic [15:0] k, input logic [15:0] f,
                                   input logic [15:0] m);
    return ((k ^ f) & m) == 16'd0;
  endfunction

endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
  import can_flt_pkg::*;
#(
  parameter int NUM_BANKS = 6,
  parameter int AW        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  output logic [63:0]      bank_data [NUM_BANKS],
  output bank_ctrl_t       bank_ctrl [NUM_BANKS]
);

  localparam int CTRL_BASE = NUM_BANKS * 8;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_data[b] <= '0;
        bank_ctrl[b] <= '0;
      end else if (we) begin
        for (int k = 0; k < 8; k++) begin
          if (addr == AW'(b * 8 + k)) bank_data[b][63 - 8*k -: 8] <= wdata;
        end
        if (addr == AW'(CTRL_BASE + b)) bank_ctrl[b] <= bank_ctrl_t'(wdata[4:0]);
      end
    end
  end

endmodule

// File: rtl/can_flt_bank.sv
module can_flt_bank
  import can_flt_pkg::*;
(
  input  logic [31:0] key,
  input  logic        ide,
  input  logic [63:0] data,
  input  bank_ctrl_t  ctrl,
  output logic [3:0]  hit,
  output logic [2:0]  nf
);

  logic [31:0] care32;
  logic [15:0] care16;
  logic [15:0] key16;
  logic [1:0]  lo_hit, hi_hit;
  logic [1:0]  lo_n, hi_n;

  assign care32 = ide ? 32'hFFFF_FFFE : 32'hFFF8_0000;
  assign care16 = ide ? 16'hFFFF : 16'hFFF8;
  assign key16  = key[31:16];

  always_comb begin
    if (ctrl.mode_lo) begin
      lo_hit = {agree16(key16, data[47:32], care16), agree16(key16, data[63:48], care16)};
      lo_n   = 2'd2;
    end else begin
      lo_hit = {1'b0, agree16(key16, data[63:48], data[47:32] & care16)};
      lo_n   = 2'd1;
    end
    if (ctrl.mode_hi) begin
      hi_hit = {agree16(key16, data[15:0], care16), agree16(key16, data[31:16], care16)};
      hi_n   = 2'd2;
    end else begin
      hi_hit = {1'b0, agree16(key16, data[31:16], data[15:0] & care16)};
      hi_n   = 2'd1;
    end
  end

  always_comb begin
    hit = '0;
    nf  = '0;
    if (ctrl.active) begin
      if (ctrl.scale == SCALE_WIDE) begin
        if (ctrl.mode_lo) begin
          hit = {2'b00, agree32(key, data[31:0], care32), agree32(key, data[63:32], care32)};
          nf  = 3'd2;
        end else begin
          hit = {3'b000, agree32(key, data[63:32], data[31:0] & care32)};
          nf  = 3'd1;
        end
      end else begin
        hit = {2'b00, lo_hit} | ({2'b00, hi_hit} << lo_n);
        nf  = 3'(lo_n) + 3'(hi_n);
      end
    end
  end

endmodule

// File: rtl/can_flt_select.sv
module can_flt_select #(
  parameter int NUM_BANKS = 6,
  parameter int FW        = 5
) (
  input  logic [3:0]    hit [NUM_BANKS],
  input  logic [2:0]    nf  [NUM_BANKS],
  output logic          any,
  output logic [FW-1:0] fnum
);

  logic [FW-1:0] base;

  always_comb begin
    any  = 1'b0;
    fnum = '0;
    base = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int s = 0; s < 4; s++) begin
        if (!any && hit[b][s]) begin
          any  = 1'b1;
          fnum = base + FW'(s);
        end
      end
      base = base + FW'(nf[b]);
    end
  end

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
#(
  parameter  int NUM_BANKS = 6,
  localparam int AW        = $clog2(NUM_BANKS * 9),
  localparam int FW        = $clog2(NUM_BANKS * 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          frm_valid,
  output logic          frm_ready,
  input  logic          frm_ide,
  input  logic          frm_rtr,
  input  logic [28:0]   frm_id,
  output logic          res_done,
  output logic          res_accept,
  output logic [FW-1:0] res_fnum
);

  logic [63:0]   bank_data [NUM_BANKS];
  bank_ctrl_t    bank_ctrl [NUM_BANKS];
  logic [3:0]    bank_hit  [NUM_BANKS];
  logic [2:0]    bank_nf   [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_act;
  logic [31:0]   key;
  logic          sel_any;
  logic [FW-1:0] sel_num;

  assign frm_ready = 1'b1;

  assign key = frm_ide ? {frm_id[28:18], frm_rtr, 1'b1, frm_id[17:0], 1'b0}
                       : {frm_id[10:0], frm_rtr, 1'b0, 19'd0};

  can_flt_regs #(.NUM_BANKS(NUM_BANKS), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .bank_data(bank_data),
    .bank_ctrl(bank_ctrl)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    can_flt_bank u_bank (
      .key (key),
      .ide (frm_ide),
      .data(bank_data[b]),
      .ctrl(bank_ctrl[b]),
      .hit (bank_hit[b]),
      .nf  (bank_nf[b])
    );
    assign bank_act[b] = bank_ctrl[b].active;
  end

  can_flt_select #(.NUM_BANKS(NUM_BANKS), .FW(FW)) u_sel (
    .hit (bank_hit),
    .nf  (bank_nf),
    .any (sel_any),
    .fnum(sel_num)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_done   <= 1'b0;
      res_accept <= 1'b0;
      res_fnum   <= '0;
    end else begin
      res_done <= frm_valid && frm_ready;
      if (frm_valid && frm_ready) begin
        res_accept <= sel_any;
        res_fnum   <= sel_any ? sel_num : '0;
      end
    end
  end

endmodule

// File: rtl/can_flt_chk.sv
module can_flt_chk #(
  parameter int NUM_BANKS = 6,
  parameter int FW        = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frm_valid,
  input logic                 frm_ready,
  input logic                 res_done,
  input logic                 res_accept,
  input logic [FW-1:0]        res_fnum,
  input logic [NUM_BANKS-1:0] bank_act
);

  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> res_done);  // R2

  AST_NO_DONE_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_done);  // R2

  AST_MISS_NUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !res_accept) |-> (res_fnum == '0));  // R9

  AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> (int'(res_fnum) < NUM_BANKS * 4));  // R6

  AST_NO_ACTIVE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && (bank_act == '0)) |=> !res_accept);  // R8

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> ($stable(res_accept) && $stable(res_fnum)));  // R11

endmodule

bind can_accept_filter can_flt_chk #(.NUM_BANKS(NUM_BANKS), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .frm_ready (frm_ready),
  .res_done  (res_done),
  .res_accept(res_accept),
  .res_fnum  (res_fnum),
  .bank_act  (bank_act)
);

// File: tb/can_accept_filter_tb.sv
`timescale 1ns/1ps
module can_accept_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic        frm_ide = 1'b0;
  logic        frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic        res_done;
  logic        res_accept;
  logic [4:0]  res_fnum;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  can_accept_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_id(frm_id),
    .res_done(res_done), .res_accept(res_accept), .res_fnum(res_fnum)
  );

  // {req[3:0], ide, rtr, id[28:0], accept, fnum[4:0]}
  localparam logic [40:0] VECS [18] = '{
    {4'd4, 1'b0, 1'b0, 29'h123,      1'b1, 5'd0},  // R4 masked hit
    {4'd4, 1'b0, 1'b1, 29'h123,      1'b1, 5'd0},  // R4 RTR not in mask
    {4'd9, 1'b0, 1'b0, 29'h124,      1'b0, 5'd0},  // R9 miss gives zero
    {4'd4, 1'b1, 1'b0, 29'h48C0000,  1'b0, 5'd0},  // R4 IDE in mask
    {4'd8, 1'b0, 1'b0, 29'h200,      1'b0, 5'd0},  // R8 inactive bank
    {4'd5, 1'b1, 1'b0, 29'h1ABCDE01, 1'b1, 5'd1},  // R5 first list entry
    {4'd5, 1'b1, 1'b0, 29'h1ABCDE00, 1'b0, 5'd0},  // R5 exact only
    {4'd7, 1'b0, 1'b1, 29'h055,      1'b1, 5'd2},  // R7 second entry, ext bits ignored
    {4'd5, 1'b0, 1'b0, 29'h055,      1'b0, 5'd0},  // R5 RTR must match
    {4'd6, 1'b0, 1'b1, 29'h703,      1'b1, 5'd3},  // R6 16-bit mask half
    {4'd6, 1'b1, 1'b0, 29'h1C000123, 1'b1, 5'd3},  // R6 extended through upper byte
    {4'd6, 1'b0, 1'b0, 29'h010,      1'b1, 5'd4},  // R6 high-half list
    {4'd6, 1'b0, 1'b0, 29'h011,      1'b1, 5'd5},  // R6
    {4'd6, 1'b0, 1'b1, 29'h011,      1'b0, 5'd0},  // R6 list exact
    {4'd6, 1'b0, 1'b1, 29'h3FF,      1'b1, 5'd7},  // R6 both-list bank
    {4'd6, 1'b0, 1'b0, 29'h3FF,      1'b1, 5'd6},  // R6
    {4'd7, 1'b0, 1'b0, 29'h001,      1'b1, 5'd9},  // R7 halfword ext bits ignored
    {4'd7, 1'b1, 1'b0, 29'h40000,    1'b0, 5'd0}   // R7 extended does not alias
  };

  function automatic logic [31:0] mk32(input logic ide, input logic rtr, input logic [28:0] id);
    return ide ? {id[28:18], rtr, 1'b1, id[17:0], 1'b0} : {id[10:0], rtr, 1'b0, 19'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [7:0] data);
    cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_word(input int bank, input int half, input logic [31:0] w);
    for (int i = 0; i < 4; i++) wr(bank * 8 + half * 4 + i, w[31 - 8*i -: 8]);
  endtask

  task automatic set_half(input int bank, input int idx, input logic [15:0] h);
    wr(bank * 8 + idx * 2, h[15:8]);
    wr(bank * 8 + idx * 2 + 1, h[7:0]);
  endtask

  task automatic send(input logic ide, input logic rtr, input logic [28:0] id,
                      input logic acc, input logic [4:0] num, input string req);
    frm_valid = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id;
    @(negedge clk);
    cfg_we = 1'b0;
    frm_valid = 1'b0;
    check({req, " done"}, 32'(res_done), 32'd1);
    check({req, " accept"}, 32'(res_accept), 32'(acc));
    check({req, " fnum"}, 32'(res_fnum), 32'(num));
    @(negedge clk);
    check("R2 done one cycle", 32'(res_done), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 done reset", 32'(res_done), 32'd0);
    check("R1 accept reset", 32'(res_accept), 32'd0);
    check("R1 fnum reset", 32'(res_fnum), 32'd0);
    check("R2 ready", 32'(frm_ready), 32'd1);
    send(1'b0, 1'b0, 29'h123, 1'b0, 5'd0, "R1 no bank active");

    // bank 0: 32-bit mask on STID and IDE
    set_word(0, 0, mk32(1'b0, 1'b0, 29'h123));
    set_word(0, 1, 32'hFFE8_0000);
    wr(48, 8'h13);
    // bank 1: 32-bit list, left inactive
    set_word(1, 0, mk32(1'b0, 1'b0, 29'h200));
    set_word(1, 1, mk32(1'b0, 1'b0, 29'h201));
    wr(49, 8'h0F);
    // bank 2: 32-bit list; second entry carries junk in extended bits
    set_word(2, 0, mk32(1'b1, 1'b0, 29'h1ABCDE01));
    set_word(2, 1, mk32(1'b0, 1'b1, 29'h055) | 32'h0003_5A5E);
    wr(50, 8'h1F);
    // bank 3: 16-bit, low mask, high list
    set_half(3, 0, mk32(1'b0, 1'b0, 29'h700) >> 16);
    set_half(3, 1, 16'hFF00);
    set_half(3, 2, mk32(1'b0, 1'b0, 29'h010) >> 16);
    set_half(3, 3, mk32(1'b0, 1'b0, 29'h011) >> 16);
    wr(51, 8'h1A);
    // bank 4: 16-bit, both list
    set_half(4, 0, mk32(1'b0, 1'b0, 29'h3FF) >> 16);
    set_half(4, 1, mk32(1'b0, 1'b1, 29'h3FF) >> 16);
    set_half(4, 2, mk32(1'b0, 1'b0, 29'h123) >> 16);
    set_half(4, 3, (mk32(1'b0, 1'b0, 29'h001) >> 16) | 32'h5);
    wr(52, 8'h1E);
    // bank 5: accept-all mask, inactive
    wr(53, 8'h03);

    for (int i = 0; i < 18; i++) begin
      send(VECS[i][36], VECS[i][35], VECS[i][34:6], VECS[i][5], VECS[i][4:0],
           $sformatf("R%0d vec%0d", VECS[i][40:37], i));
    end

    // R10: write lands on the same edge as the frame
    cfg_we = 1'b1; cfg_addr = 6'd1; cfg_wdata = 8'h80;
    send(1'b0, 1'b0, 29'h124, 1'b0, 5'd0, "R10 same-edge write");
    send(1'b0, 1'b0, 29'h124, 1'b1, 5'd0, "R10 next frame");
    send(1'b0, 1'b0, 29'h123, 1'b1, 5'd8, "R9 falls to later filter");

    // R8 / R3: activating bank 1 renumbers later banks
    wr(49, 8'h1F);
    send(1'b0, 1'b0, 29'h200, 1'b1, 5'd1, "R3 control write");
    send(1'b1, 1'b0, 29'h1ABCDE01, 1'b1, 5'd3, "R8 numbers shift");
    send(1'b0, 1'b0, 29'h123, 1'b1, 5'd10, "R8 numbers shift");

    wr(53, 8'h13);
    send(1'b0, 1'b0, 29'h5A5, 1'b1, 5'd12, "R6 last bank number");
    send(1'b0, 1'b0, 29'h124, 1'b1, 5'd0, "R9 lowest wins");

    repeat (3) @(negedge clk);
    check("R11 done idle", 32'(res_done), 32'd0);
    check("R11 accept held", 32'(res_accept), 32'd1);
    check("R11 fnum held", 32'(res_fnum), 32'd0);
    send(1'b0, 1'b0, 29'h7FF, 1'b1, 5'd12, "R11 next result");
    repeat (2) @(negedge clk);
    check("R11 fnum held", 32'(res_fnum), 32'd12);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 accept cleared", 32'(res_accept), 32'd0);
    check("R1 fnum cleared", 32'(res_fnum), 32'd0);
    send(1'b0, 1'b0, 29'h124, 1'b0, 5'd0, "R1 config cleared");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule